// File: doc/BRIEF.md
# Opcode-Table Control Unit with Branch, Trap and Reset Overrides

This block is the decode stage of a single-cycle 32-bit processor. A 64-entry table, indexed by the 6-bit opcode, gives an 18-bit control word. That word steers the datapath: the ALU function, the two operand multiplexers, the data-memory read and write enables, the next-PC source, the register-file address selects, the write-back source and the register write enable. Every entry is computed at elaboration time. Bits the datapath does not care about are filled with zero.

Three override stages follow the table, and each later stage has priority over the earlier ones. The branch stage turns a conditional branch into a taken branch, based on the zero flag. The trap stage redirects execution to the interrupt vector. It does this only when an interrupt is requested and the processor is in user mode, which means the PC supervisor bit is clear. The reset stage holds the memory write enable and the register write enable low while the active-low processor reset is asserted, so the memory write strobe always has a defined level at a clock edge. The block is purely combinational.

Top module: `ctl_unit`

## Requirements
- R1: The control word, from most significant to least significant bit, is: ALU function (6), A select, B select, memory read, memory write, PC select (3), B-read-address select, write-address select, write-back select (2), register write. PC select codes are 0 for next, 1 for taken branch, 2 for jump, 3 for illegal-opcode trap and 4 for interrupt. Write-back codes are 0 for PC+4, 1 for ALU and 2 for memory.
- R2: Any opcode not listed in R3 to R5 gives PC select 3, write-address select 1, write-back 0 and register write 1. All other fields of the word are 0.
- R3: Opcodes 0x20 to 0x2F give ALU function {00, opcode[3:0]}, B select 0, write-back 1, register write 1, and 0 in all other fields. Opcodes 0x30 to 0x3F give the same word with B select 1.
- R4: Opcode 0x18 (load) gives B select 1, memory read 1, write-back 2 and register write 1. Opcode 0x1F (PC-relative load) gives ALU function 0x1A, A select 1, memory read 1, write-back 2 and register write 1. Both have 0 in all other fields.
- R5: Opcode 0x19 (store) gives B select 1, memory write 1, B-read-address select 1 and register write 0. Opcode 0x1B (jump) gives PC select 2 and register write 1. Both have 0 in all other fields.
- R6: Opcode 0x1C (branch-if-zero) gives PC select 1 when zero is 1 and PC select 0 when zero is 0. In both cases register write is 1 and write-back is 0.
- R7: Opcode 0x1D (branch-if-nonzero) gives PC select 1 when zero is 0 and PC select 0 when zero is 1. In both cases register write is 1 and write-back is 0.
- R8: When an interrupt is requested and the supervisor bit is 0, the outputs are memory write 0, PC select 4, write-address select 1, write-back 0 and register write 1. This applies whatever the opcode, and it overrides a taken branch. The other fields keep their table values.
- R9: When the supervisor bit is 1, an interrupt request has no effect on any output.
- R10: While reset is low, memory write and register write are 0. All other fields keep the values they would have with reset high, including a PC select of 4 from an accepted interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field |
| zero_i | input | 1 | Register A equals zero |
| irq_i | input | 1 | Interrupt request |
| super_i | input | 1 | PC supervisor bit (1 = supervisor mode) |
| rst_n | input | 1 | Active-low processor reset |
| alu_fn_o | output | 6 | ALU function code |
| a_sel_o | output | 1 | ALU A operand select |
| b_sel_o | output | 1 | ALU B operand select |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| pc_sel_o | output | 3 | Next-PC source |
| rb_sel_o | output | 1 | Second register read address select |
| wa_sel_o | output | 1 | Register write address select |
| wd_sel_o | output | 2 | Register write-back source |
| rf_we_o | output | 1 | Register file write enable |

## Verification
The opcode space is covered in three ways. Every illegal opcode is swept, which shows that no unused entry leaks a write enable or a wrong PC source. Several arithmetic opcodes, in both register and literal form, separate the function bits of the opcode from the operand-select bit. Each memory, jump and branch opcode is tried on its own.

Both branches are driven with both values of the zero flag, so the two taken and the two not-taken cases are told apart. An interrupt is requested over a plain ALU operation, a store and a taken branch, first in user mode and then in supervisor mode. This shows the priority of the trap and shows that supervisor mode blocks it. Reset is combined with a store and with an accepted interrupt, which shows that it clears only the two write enables.

// File: rtl/ctl_unit_pkg.sv
package ctl_unit_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int PCS_W = 3;
  localparam int WDS_W = 2;

  typedef struct packed {
    logic [FN_W-1:0]  fn;
    logic             a_sel;
    logic             b_sel;
    logic             mem_rd;
    logic             mem_wr;
    logic [PCS_W-1:0] pc_sel;
    logic             rb_sel;
    logic             wa_sel;
    logic [WDS_W-1:0] wd_sel;
    logic             rf_we;
  } ctl_word_t;

  localparam int CW_W = $bits(ctl_word_t);

  localparam logic [PCS_W-1:0] PCS_NEXT = 3'd0;
  localparam logic [PCS_W-1:0] PCS_BR   = 3'd1;
  localparam logic [PCS_W-1:0] PCS_JMP  = 3'd2;
  localparam logic [PCS_W-1:0] PCS_ILL  = 3'd3;
  localparam logic [PCS_W-1:0] PCS_IRQ  = 3'd4;

  localparam logic [WDS_W-1:0] WD_PC  = 2'd0;
  localparam logic [WDS_W-1:0] WD_ALU = 2'd1;
  localparam logic [WDS_W-1:0] WD_MEM = 2'd2;

  localparam logic [OP_W-1:0] OPC_LD   = 6'h18;
  localparam logic [OP_W-1:0] OPC_ST   = 6'h19;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'h1B;
  localparam logic [OP_W-1:0] OPC_BRZ  = 6'h1C;
  localparam logic [OP_W-1:0] OPC_BRNZ = 6'h1D;
  localparam logic [OP_W-1:0] OPC_LDR  = 6'h1F;
  localparam logic [FN_W-1:0] FN_ADD   = 6'h00;
  localparam logic [FN_W-1:0] FN_PASSA = 6'h1A;

  // Table entry for one opcode; unlisted opcodes decode as illegal.
  function automatic ctl_word_t decode_entry(input logic [OP_W-1:0] op);
    ctl_word_t w;
    w = '0;
    if (op[OP_W-1 -: 2] == 2'b10 || op[OP_W-1 -: 2] == 2'b11) begin
      w.fn     = {2'b00, op[3:0]};
      w.b_sel  = op[4];
      w.wd_sel = WD_ALU;
      w.rf_we  = 1'b1;
    end else begin
      unique case (op)
        OPC_LD:   begin w.fn = FN_ADD; w.b_sel = 1'b1; w.mem_rd = 1'b1;
                        w.wd_sel = WD_MEM; w.rf_we = 1'b1; end
        OPC_ST:   begin w.fn = FN_ADD; w.b_sel = 1'b1; w.mem_wr = 1'b1;
                        w.rb_sel = 1'b1; end
        OPC_JMP:  begin w.pc_sel = PCS_JMP; w.wd_sel = WD_PC; w.rf_we = 1'b1; end
        OPC_BRZ,
        OPC_BRNZ: begin w.pc_sel = PCS_NEXT; w.wd_sel = WD_PC; w.rf_we = 1'b1; end
        OPC_LDR:  begin w.fn = FN_PASSA; w.a_sel = 1'b1; w.mem_rd = 1'b1;
                        w.wd_sel = WD_MEM; w.rf_we = 1'b1; end
        default:  begin w.pc_sel = PCS_ILL; w.wa_sel = 1'b1; w.wd_sel = WD_PC;
                        w.rf_we = 1'b1; end
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/ctl_rom.sv
module ctl_rom
  import ctl_unit_pkg::*;
#(
  parameter int ADDR_W = OP_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output ctl_word_t         word_o
);
  localparam int DEPTH = 1 << ADDR_W;

  ctl_word_t table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = decode_entry(OP_W'(g));
  end

  assign word_o = table_q[addr_i];

  always_comb begin
    if (word_o.mem_wr) begin
      assert_store_no_writeback_R5: assert (!word_o.rf_we && !word_o.mem_rd)
        else $error("store entry enables a write-back or read");
    end
  end
endmodule

// File: rtl/ctl_branch.sv
module ctl_branch
  import ctl_unit_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  input  logic            zero_i,
  input  ctl_word_t       word_i,
  output ctl_word_t       word_o
);
  logic is_brz, is_brnz, taken;

  always_comb begin
    is_brz  = (opcode_i == OPC_BRZ);
    is_brnz = (opcode_i == OPC_BRNZ);
    taken   = (is_brz && zero_i) || (is_brnz && !zero_i);
    word_o  = word_i;
    if (taken) word_o.pc_sel = PCS_BR;
  end

  // Table must hold branches at "next" so that only this stage selects taken.
  always_comb begin
    if (is_brz || is_brnz) begin
      assert_branch_table_next_R6: assert (word_i.pc_sel == PCS_NEXT)
        else $error("branch table entry is not PC select next");
    end
  end
endmodule

// File: rtl/ctl_trap.sv
module ctl_trap
  import ctl_unit_pkg::*;
(
  input  logic      irq_i,
  input  logic      super_i,
  input  logic      rst_n,
  input  ctl_word_t word_i,
  output ctl_word_t word_o
);
  logic irq_take;

  always_comb begin
    irq_take = irq_i && !super_i;
    word_o   = word_i;
    if (irq_take) begin
      word_o.mem_wr = 1'b0;
      word_o.pc_sel = PCS_IRQ;
      word_o.wa_sel = 1'b1;
      word_o.wd_sel = WD_PC;
      word_o.rf_we  = 1'b1;
    end
    if (!rst_n) begin
      word_o.mem_wr = 1'b0;
      word_o.rf_we  = 1'b0;
    end
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!word_o.mem_wr && !word_o.rf_we)
        else $error("write enable active during reset");
    end
    if (super_i) begin
      assert_super_blocks_irq_R9: assert (word_o.pc_sel == word_i.pc_sel)
        else $error("interrupt accepted in supervisor mode");
    end
    if (irq_i && !super_i) begin
      assert_irq_vector_R8: assert (word_o.pc_sel == PCS_IRQ && !word_o.mem_wr)
        else $error("accepted interrupt without vector");
    end
  end
endmodule

// File: rtl/ctl_unit.sv
module ctl_unit
  import ctl_unit_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic       zero_i,
  input  logic       irq_i,
  input  logic       super_i,
  input  logic       rst_n,
  output logic [5:0] alu_fn_o,
  output logic       a_sel_o,
  output logic       b_sel_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic [2:0] pc_sel_o,
  output logic       rb_sel_o,
  output logic       wa_sel_o,
  output logic [1:0] wd_sel_o,
  output logic       rf_we_o
);
  ctl_word_t rom_word, br_word, fin_word;

  ctl_rom #(.ADDR_W(OP_W)) u_rom (
    .addr_i (opcode_i),
    .word_o (rom_word)
  );

  ctl_branch u_branch (
    .opcode_i (opcode_i),
    .zero_i   (zero_i),
    .word_i   (rom_word),
    .word_o   (br_word)
  );

  ctl_trap u_trap (
    .irq_i   (irq_i),
    .super_i (super_i),
    .rst_n   (rst_n),
    .word_i  (br_word),
    .word_o  (fin_word)
  );

  assign alu_fn_o = fin_word.fn;
  assign a_sel_o  = fin_word.a_sel;
  assign b_sel_o  = fin_word.b_sel;
  assign mem_rd_o = fin_word.mem_rd;
  assign mem_wr_o = fin_word.mem_wr;
  assign pc_sel_o = fin_word.pc_sel;
  assign rb_sel_o = fin_word.rb_sel;
  assign wa_sel_o = fin_word.wa_sel;
  assign wd_sel_o = fin_word.wd_sel;
  assign rf_we_o  = fin_word.rf_we;

  always_comb begin
    if (pc_sel_o == 3'd1) begin
      assert_taken_only_on_branch_R6: assert (opcode_i == OPC_BRZ || opcode_i == OPC_BRNZ)
        else $error("taken-branch select on non-branch opcode");
    end
  end
endmodule

// File: tb/tb_ctl_unit.sv
module tb_ctl_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [5:0] opcode;
  logic zero, irq, sup, rst_n;
  logic [5:0] alu_fn;
  logic a_sel, b_sel, mem_rd, mem_wr, rb_sel, wa_sel, rf_we;
  logic [2:0] pc_sel;
  logic [1:0] wd_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  ctl_unit dut (
    .opcode_i (opcode), .zero_i (zero), .irq_i (irq), .super_i (sup),
    .rst_n (rst_n), .alu_fn_o (alu_fn), .a_sel_o (a_sel), .b_sel_o (b_sel),
    .mem_rd_o (mem_rd), .mem_wr_o (mem_wr), .pc_sel_o (pc_sel),
    .rb_sel_o (rb_sel), .wa_sel_o (wa_sel), .wd_sel_o (wd_sel), .rf_we_o (rf_we)
  );

  function automatic logic [17:0] mk(input logic [5:0] fn, input logic a, input logic b,
                                     input logic rd, input logic wr, input logic [2:0] pcs,
                                     input logic rb, input logic wa, input logic [1:0] wd,
                                     input logic we);
    return {fn, a, b, rd, wr, pcs, rb, wa, wd, we};
  endfunction

  task automatic drive(input logic [5:0] op, input logic z, input logic i,
                       input logic s, input logic r);
    @(posedge clk);
    #1;
    opcode = op; zero = z; irq = i; sup = s; rst_n = r;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [17:0] exp);
    logic [17:0] act;
    act = {alu_fn, a_sel, b_sel, mem_rd, mem_wr, pc_sel, rb_sel, wa_sel, wd_sel, rf_we};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%h z=%0b irq=%0b sup=%0b rst_n=%0b actual=%h expected=%h",
               req, opcode, zero, irq, sup, rst_n, act, exp);
    end
  endtask

  localparam logic [17:0] W_ILL = 18'h00069;

  task automatic t_reset_state;  // R10
    drive(6'h19, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 reset store", mk(6'h00, 0, 1, 0, 0, 3'd0, 1, 0, 2'd0, 0));
    drive(6'h20, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 reset with irq", mk(6'h00, 0, 0, 0, 0, 3'd4, 0, 1, 2'd0, 0));
  endtask

  task automatic t_illegal_sweep;  // R1 R2
    for (int k = 0; k < 32; k++) begin
      if (!(k == 'h18 || k == 'h19 || k == 'h1B || k == 'h1C || k == 'h1D || k == 'h1F)) begin
        drive(6'(k), 1'b0, 1'b0, 1'b0, 1'b1);
        check("R2 illegal opcode", W_ILL);
      end
    end
    drive(6'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R1 illegal word layout", mk(6'h00, 0, 0, 0, 0, 3'd3, 0, 1, 2'd0, 1));
  endtask

  task automatic t_alu_ops;  // R3
    logic [5:0] ops [6] = '{6'h20, 6'h25, 6'h2F, 6'h30, 6'h3A, 6'h3F};
    for (int k = 0; k < 6; k++) begin
      drive(ops[k], 1'b0, 1'b0, 1'b0, 1'b1);
      check("R3 alu op", mk({2'b00, ops[k][3:0]}, 0, ops[k][4], 0, 0, 3'd0, 0, 0, 2'd1, 1));
    end
  endtask

  task automatic t_memory_jump;  // R4 R5
    drive(6'h18, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 load", mk(6'h00, 0, 1, 1, 0, 3'd0, 0, 0, 2'd2, 1));
    drive(6'h1F, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 pc-relative load", mk(6'h1A, 1, 0, 1, 0, 3'd0, 0, 0, 2'd2, 1));
    drive(6'h19, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 store", mk(6'h00, 0, 1, 0, 1, 3'd0, 1, 0, 2'd0, 0));
    drive(6'h1B, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R5 jump", mk(6'h00, 0, 0, 0, 0, 3'd2, 0, 0, 2'd0, 1));
  endtask

  task automatic t_branches;  // R6 R7
    drive(6'h1C, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R6 brz taken", mk(6'h00, 0, 0, 0, 0, 3'd1, 0, 0, 2'd0, 1));
    drive(6'h1C, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 brz not taken", mk(6'h00, 0, 0, 0, 0, 3'd0, 0, 0, 2'd0, 1));
    drive(6'h1D, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 brnz taken", mk(6'h00, 0, 0, 0, 0, 3'd1, 0, 0, 2'd0, 1));
    drive(6'h1D, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R7 brnz not taken", mk(6'h00, 0, 0, 0, 0, 3'd0, 0, 0, 2'd0, 1));
  endtask

  task automatic t_irq_user;  // R8
    drive(6'h20, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R8 irq over alu", mk(6'h00, 0, 0, 0, 0, 3'd4, 0, 1, 2'd0, 1));
    drive(6'h19, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R8 irq over store", mk(6'h00, 0, 1, 0, 0, 3'd4, 1, 1, 2'd0, 1));
    drive(6'h1C, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R8 irq over taken branch", mk(6'h00, 0, 0, 0, 0, 3'd4, 0, 1, 2'd0, 1));
  endtask

  task automatic t_irq_super;  // R9
    drive(6'h20, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 sup irq alu", mk(6'h00, 0, 0, 0, 0, 3'd0, 0, 0, 2'd1, 1));
    drive(6'h19, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 sup irq store", mk(6'h00, 0, 1, 0, 1, 3'd0, 1, 0, 2'd0, 0));
    drive(6'h1C, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R9 sup irq branch", mk(6'h00, 0, 0, 0, 0, 3'd1, 0, 0, 2'd0, 1));
  endtask

  initial begin
    opcode = '0; zero = 1'b0; irq = 1'b0; sup = 1'b0; rst_n = 1'b0;
    t_reset_state();
    t_illegal_sweep();
    t_alu_ops();
    t_memory_jump();
    t_branches();
    t_irq_user();
    t_irq_super();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule